// File: doc/BRIEF.md
# Per-Space DRAM Same-Page Hint Detector

This block sits beside a processor's external bus and watches each bus cycle. It tells an external memory controller whether the access just started falls in the same DRAM row as the last access it recorded. The processor issues cycles into three memory spaces: program, X data and Y data. Each space has its own enable bit. The enable bit decides two things for a cycle in that space: whether the hint may assert, and whether that cycle's row becomes the new reference row.

The row is taken from the bus address. The low `COL_W` bits are treated as the column and dropped. The next `ROW_W` bits form the row, and they are ANDed with the `ROW_MASK` parameter. Address bits above the row field play no part. The block keeps one latched row and one valid flag. It has no notion of refresh or of RAS/CAS timeouts; the controller handles those, for example by ignoring the hint after a refresh. The result is registered, so the hint appears exactly one clock after the cycle-start strobe.

Top module: `pagehit_tracker`

## Requirements
- R1: After reset, `same_page` is 0 and no row is held. The first enabled cycle after reset reports no hit.
- R2: `same_page` can be 1 only in the clock that directly follows a clock with `cyc_start` high. It is 0 in every clock that follows a clock without a strobe.
- R3: A cycle in a space whose enable bit is 0 gives `same_page` = 0 on the following clock.
- R4: A cycle in an enabled space, while a row is held, gives `same_page` = 1 on the following clock when its row equals the held row, and 0 when it differs.
- R5: Only address bits [COL_W+ROW_W-1 : COL_W], ANDed with `ROW_MASK`, take part in the comparison. Column bits and bits above the row field have no effect.
- R6: A cycle in a disabled space leaves the held row and the valid flag unchanged.
- R7: Every enabled cycle loads its row as the held row, whether it hit or missed.
- R8: The space code is 2'b00 for program, 2'b01 for X data and 2'b10 for Y data. Code 2'b11 is never enabled.
- R9: All eight settings of (`en_prog`, `en_xdat`, `en_ydat`) are legal. Each space is gated only by its own bit.
- R10: Asserting reset in the middle of operation clears the held row's valid flag, so the next enabled cycle misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | High for one clock at the start of each bus cycle |
| addr | input | ADDR_W | Bus address of the cycle |
| space | input | 2 | Memory space code of the cycle (see R8) |
| en_prog | input | 1 | Page hint enable for program space |
| en_xdat | input | 1 | Page hint enable for X data space |
| en_ydat | input | 1 | Page hint enable for Y data space |
| same_page | output | 1 | Registered same-row hint, one clock after the strobe |

## Verification
Directed sequences cover the following cases:
- The first access after reset, and again after a reset applied mid-stream, which separates a cleared valid flag from a stale row.
- Same-row accesses that differ only in column or upper bits, which separate correct field extraction from a full-address compare.
- A disabled-space access to a foreign row inserted between two enabled accesses to one row, which shows whether disabled cycles corrupt the latch.
- A miss followed by a repeat of the missed row, which proves misses still load.

A walk through all eight enable settings, combined with every space code, separates per-space gating from a shared or swapped enable. Random cycles then draw their rows from a small pool, so hits and misses both occur often. They also mix enables and idle gaps, so the one-clock latency is checked against a bench reference model.

// File: rtl/pagehit_pkg.sv
package pagehit_pkg;
  typedef enum logic [1:0] {
    SP_PROG = 2'b00,
    SP_XDAT = 2'b01,
    SP_YDAT = 2'b10,
    SP_NONE = 2'b11
  } space_e;

  localparam int NUM_SPACES = 3;
endpackage

// File: rtl/space_gate.sv
module space_gate
  import pagehit_pkg::*;
(
  input  space_e                 space,
  input  logic [NUM_SPACES-1:0]  en_vec,
  output logic                   space_on
);
  logic [NUM_SPACES-1:0] hit_vec;

  // One-hot decode of the space code, one term per space.
  for (genvar i = 0; i < NUM_SPACES; i++) begin : g_dec
    assign hit_vec[i] = (space == space_e'(i)) && en_vec[i];
  end

  assign space_on = |hit_vec;

  // R8: the reserved code never enables a cycle
  always_comb begin
    if (space == SP_NONE) assert (!space_on) else $error("p_reserved_off_r8");
  end
endmodule

// File: rtl/row_extract.sv
module row_extract #(
  parameter int ADDR_W = 32,
  parameter int COL_W  = 9,
  parameter int ROW_W  = 11,
  parameter logic [ROW_W-1:0] ROW_MASK = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row
);
  localparam int TOP_BIT = COL_W + ROW_W;

  if (TOP_BIT > ADDR_W) begin : g_bad
    initial $error("row field exceeds address width");
  end

  logic [ADDR_W-1:0] shifted;
  assign shifted = addr >> COL_W;
  assign row     = shifted[ROW_W-1:0] & ROW_MASK;
endmodule

// File: rtl/row_register.sv
module row_register #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ROW_W-1:0] row_in,
  output logic             valid_q,
  output logic             match
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      row_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      row_q   <= row_in;
    end
  end

  assign match = valid_q && (row_q == row_in);

  // R6: no load leaves the held row untouched
  p_hold_row_r6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(row_q) && $stable(valid_q));

  // R7: a load always leaves a valid row behind
  p_load_valid_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> valid_q);
endmodule

// File: rtl/pagehit_tracker.sv
module pagehit_tracker
  import pagehit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int COL_W  = 9,
  parameter int ROW_W  = 11,
  parameter logic [ROW_W-1:0] ROW_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        space,
  input  logic              en_prog,
  input  logic              en_xdat,
  input  logic              en_ydat,
  output logic              same_page
);
  logic             space_on;
  logic             load;
  logic             row_valid;
  logic             row_match;
  logic [ROW_W-1:0] cur_row;

  space_gate u_gate (
    .space    (space_e'(space)),
    .en_vec   ({en_ydat, en_xdat, en_prog}),
    .space_on (space_on)
  );

  row_extract #(
    .ADDR_W   (ADDR_W),
    .COL_W    (COL_W),
    .ROW_W    (ROW_W),
    .ROW_MASK (ROW_MASK)
  ) u_extract (
    .addr (addr),
    .row  (cur_row)
  );

  assign load = cyc_start && space_on;

  row_register #(.ROW_W(ROW_W)) u_row (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .row_in  (cur_row),
    .valid_q (row_valid),
    .match   (row_match)
  );

  always_ff @(posedge clk) begin
    if (rst) same_page <= 1'b0;
    else     same_page <= load && row_match;
  end

  // R2: no strobe, no hint on the next clock
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |=> !same_page);

  // R3: disabled space gives no hint
  p_disabled_low_r3: assert property (@(posedge clk) disable iff (rst)
    cyc_start && !space_on |=> !same_page);

  // R1: nothing held means no hit
  p_empty_miss_r1: assert property (@(posedge clk) disable iff (rst)
    !row_valid |=> !same_page);
endmodule

// File: tb/pagehit_tracker_test.sv
`timescale 1ns/1ps
module pagehit_tracker_test;
  localparam int ADDR_W = 32;
  localparam int COL_W  = 9;
  localparam int ROW_W  = 11;

  logic              clk = 1'b0;
  logic              rst;
  logic              cyc_start;
  logic [ADDR_W-1:0] addr;
  logic [1:0]        space;
  logic              en_prog, en_xdat, en_ydat;
  logic              same_page;

  int checks = 0;
  int fails  = 0;

  logic             ref_valid;
  logic [ROW_W-1:0] ref_row;

  always #2 clk = ~clk;

  pagehit_tracker #(.ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W)) uut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .addr(addr), .space(space),
    .en_prog(en_prog), .en_xdat(en_xdat), .en_ydat(en_ydat), .same_page(same_page)
  );

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[COL_W +: ROW_W];
  endfunction

  function automatic logic on_of(input logic [1:0] sp, input logic [2:0] en);
    case (sp)
      2'b00:   return en[0];
      2'b01:   return en[1];
      2'b10:   return en[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(input logic [ROW_W-1:0] r,
                                                input logic [31:0] noise);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(noise);
    a[COL_W +: ROW_W] = r;
    return a;
  endfunction

  task automatic check(input logic exp, input string tag);
    checks++;
    if (same_page !== exp) begin
      fails++;
      $display("FAIL %s: same_page=%b expected %b at %0t", tag, same_page, exp, $time);
    end
  endtask

  // en = {y, x, p}
  task automatic bus_cycle(input logic [1:0] sp, input logic [ADDR_W-1:0] a,
                           input logic [2:0] en, input string tag);
    logic exp;
    logic on;
    on  = on_of(sp, en);
    exp = on && ref_valid && (ref_row == row_of(a));
    cyc_start = 1'b1; addr = a; space = sp;
    {en_ydat, en_xdat, en_prog} = en;
    @(negedge clk);
    cyc_start = 1'b0;
    if (on) begin ref_valid = 1'b1; ref_row = row_of(a); end
    check(exp, tag);
  endtask

  task automatic idle(input string tag);
    cyc_start = 1'b0;
    @(negedge clk);
    check(1'b0, tag);
  endtask

  task automatic do_reset;
    rst = 1'b1; cyc_start = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    ref_valid = 1'b0; ref_row = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [ROW_W-1:0] pool [4];
    void'($urandom(32'd1234));
    addr = '0; space = 2'b00; en_prog = 0; en_xdat = 0; en_ydat = 0;
    cyc_start = 0; rst = 1'b1;
    @(negedge clk);
    do_reset();
    check(1'b0, "R1 reset state");

    // R1: first enabled access misses
    bus_cycle(2'b00, mk_addr(11'h155, 32'h0000_0012), 3'b111, "R1 first access");
    // R4: same row hits, different row misses
    bus_cycle(2'b00, mk_addr(11'h155, 32'h0000_0034), 3'b111, "R4 same row");
    idle("R2 idle after hit");
    // R5: column and upper bits do not matter
    bus_cycle(2'b01, mk_addr(11'h155, 32'hFFF0_01FF), 3'b111, "R5 column/upper bits");
    bus_cycle(2'b10, mk_addr(11'h2AA, 32'h0), 3'b111, "R4 different row");
    // R7: missed row was loaded
    bus_cycle(2'b10, mk_addr(11'h2AA, 32'h0000_0001), 3'b111, "R7 miss then repeat");
    // R6: disabled cycle to another row does not disturb
    bus_cycle(2'b01, mk_addr(11'h0F0, 32'h0), 3'b101, "R3 disabled X");
    bus_cycle(2'b00, mk_addr(11'h2AA, 32'h5), 3'b101, "R6 latch kept");
    // R8: reserved code with all enables
    bus_cycle(2'b11, mk_addr(11'h2AA, 32'h0), 3'b111, "R8 reserved space");
    // R9: all eight enable combos against every space, same row
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 4; s++) begin
        bus_cycle(2'(s), mk_addr(11'h2AA, 32'(s)), 3'(e), "R9 enable combo");
      end
    end
    // R10: mid-run reset clears valid
    bus_cycle(2'b00, mk_addr(11'h033, 32'h0), 3'b001, "R4 load before reset");
    do_reset();
    check(1'b0, "R10 output after reset");
    bus_cycle(2'b00, mk_addr(11'h033, 32'h0), 3'b001, "R10 miss after reset");
    bus_cycle(2'b00, mk_addr(11'h033, 32'h7), 3'b001, "R4 hit after reload");

    // random phase
    for (int i = 0; i < 4; i++) pool[i] = ROW_W'($urandom);
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 4) == 0) idle("R2 random idle");
      else bus_cycle(2'($urandom_range(0, 3)),
                     mk_addr(pool[$urandom_range(0, 3)], $urandom),
                     3'($urandom_range(0, 7)), "R4 random cycle");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule